// File: doc/BRIEF.md
# Configurable Microcontroller Bus Strobe Adapter

This block sits between an external microcontroller bus and the internal memory and I/O logic of a chip. It takes the controller's strobe pins, the multiplexed address/data lines and a few static configuration bits. From these it produces a latched address and single-cycle internal access strobes, all in the system clock domain. The same two strobe pins are read in one of two ways. They can be a pair of active-low read and write strobes, or a direction line paired with an active-high enable.

All pins pass through two-flop synchronizers. A two-state sequencer (`ST_IDLE`, `ST_HOLD`) turns each access into exactly one strobe. The transition `ST_IDLE -> ST_HOLD` is taken when an access kind other than "none" is decoded, and the strobe is issued on that edge. The transition `ST_HOLD -> ST_IDLE` is taken when the decode returns to "none". The self-loops `ST_IDLE -> ST_IDLE` (nothing decoded) and `ST_HOLD -> ST_HOLD` (access still present) issue no strobe. The address register follows the bus while the address strobe is at its configured active level, and it holds once that level ends. A program-store-enable pin opens a separate program space when the space-split option is set.

Top module: `bus_strobe_adapter`

## Requirements
- R1: A synchronous active-high `rst` clears `addr_q` and all four strobes to 0, and the sequencer returns to `ST_IDLE`.
- R2: With `cfg_dir_mode`=0, a low on `pin_wr_dir` is a write and a low on `pin_rd_en` is a read.
- R3: With `cfg_dir_mode`=1, `pin_rd_en` high with `pin_wr_dir` high is a read, and `pin_rd_en` high with `pin_wr_dir` low is a write. While `pin_rd_en` is low, `pin_wr_dir` has no effect.
- R4: With `cfg_ale_high`=1, `addr_q` takes the synchronized bus value while the synchronized `pin_ale` is 1. It holds its value while `pin_ale` is 0.
- R5: With `cfg_ale_high`=0, `addr_q` follows the bus while `pin_ale` is 0 and holds while it is 1.
- R6: With `cfg_split_space`=1, a low on `pin_pse_n` produces `prog_rd_stb`, and a data read produces `io_rd_stb`. `mem_rd_stb` is never raised.
- R7: With `cfg_split_space`=0, `pin_pse_n` has no effect, a data read produces `mem_rd_stb`, and `prog_rd_stb` and `io_rd_stb` are never raised.
- R8: The access kinds are ranked: program read (split mode only) above data read above write. No `io_wr_stb` is issued while `pin_pse_n` is low in split mode, and at most one strobe is high in any cycle.
- R9: Each access raises its strobe for exactly one clock. The strobe appears on the third rising edge after the pin change (two synchronizer edges plus one sequencer edge). No further strobe follows until the decode has returned to "none", even if the access kind changes while held.
- R10: With `cfg_dir_mode`=0, both strobe pins low together count as a read.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| pin_wr_dir | input | 1 | Write strobe (active low) or direction line (1 = read) |
| pin_rd_en | input | 1 | Read strobe (active low) or data enable (active high) |
| pin_ale | input | 1 | Address-latch strobe, polarity set by `cfg_ale_high` |
| pin_pse_n | input | 1 | Program-store enable, active low |
| bus_ad | input | AW | Multiplexed address/data lines |
| cfg_dir_mode | input | 1 | 0 = separate read/write strobes, 1 = direction plus enable |
| cfg_ale_high | input | 1 | 1 = address strobe active high, 0 = active low |
| cfg_split_space | input | 1 | 1 = separate program and data spaces, 0 = combined |
| addr_q | output | AW | Latched address |
| prog_rd_stb | output | 1 | One-cycle program-memory read |
| io_rd_stb | output | 1 | One-cycle I/O read (split mode) |
| io_wr_stb | output | 1 | One-cycle write |
| mem_rd_stb | output | 1 | One-cycle combined-space read |

## Verification
The assertions assume that the three configuration inputs change only while the pins decode to no access and the sequencer has settled in `ST_IDLE`. They also assume reset is held long enough to fill the synchronizers with pin values. The stimulus returns the pins to their idle levels for several clocks before every configuration change. It holds reset for four clocks with idle pins. Only then does it drive directed access patterns and random pin activity under each fixed configuration.

// File: rtl/bsa_pkg.sv
package bsa_pkg;
    typedef enum logic [2:0] {
        ACC_NONE  = 3'd0,
        ACC_PROG  = 3'd1,
        ACC_IORD  = 3'd2,
        ACC_MEMRD = 3'd3,
        ACC_WR    = 3'd4
    } acc_kind_t;

    typedef enum logic {
        ST_IDLE = 1'b0,
        ST_HOLD = 1'b1
    } seq_state_t;
endpackage

// File: rtl/bsa_sync.sv
module bsa_sync #(
    parameter int W = 1
) (
    input  logic         clk,
    input  logic [W-1:0] d,
    output logic [W-1:0] q
);
    logic [W-1:0] meta;

    always_ff @(posedge clk) begin
        meta <= d;
        q    <= meta;
    end
endmodule

// File: rtl/bsa_addr_capture.sv
module bsa_addr_capture #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ale_s,
    input  logic          cfg_ale_high,
    input  logic [AW-1:0] bus_s,
    output logic [AW-1:0] addr_q
);
    logic ale_act;

    assign ale_act = cfg_ale_high ? ale_s : ~ale_s;

    always_ff @(posedge clk) begin
        if (rst)          addr_q <= '0;
        else if (ale_act) addr_q <= bus_s;
    end

    // R4 and R5: outside the active level the address holds
    assert_addr_hold_R4: assert property (@(posedge clk) disable iff (rst)
        !ale_act |=> $stable(addr_q));

    // R5 and R4: inside the active level the address tracks the bus
    assert_addr_follow_R5: assert property (@(posedge clk) disable iff (rst)
        ale_act |=> addr_q == $past(bus_s));
endmodule

// File: rtl/bsa_access_fsm.sv
module bsa_access_fsm
    import bsa_pkg::*;
(
    input  logic clk,
    input  logic rst,
    input  logic wr_dir_s,
    input  logic rd_en_s,
    input  logic pse_n_s,
    input  logic cfg_dir_mode,
    input  logic cfg_split_space,
    output logic prog_rd_stb,
    output logic io_rd_stb,
    output logic io_wr_stb,
    output logic mem_rd_stb
);
    seq_state_t state, nxt;
    acc_kind_t  kind;
    logic       rd_cond, wr_cond, prog_cond;

    always_comb begin
        rd_cond   = cfg_dir_mode ? (rd_en_s & wr_dir_s)  : ~rd_en_s;
        wr_cond   = cfg_dir_mode ? (rd_en_s & ~wr_dir_s) : ~wr_dir_s;
        prog_cond = cfg_split_space & ~pse_n_s;
        if (prog_cond)    kind = ACC_PROG;
        else if (rd_cond) kind = cfg_split_space ? ACC_IORD : ACC_MEMRD;
        else if (wr_cond) kind = ACC_WR;
        else              kind = ACC_NONE;
    end

    always_comb begin
        nxt = state;
        unique case (state)
            ST_IDLE: if (kind != ACC_NONE) nxt = ST_HOLD;
            ST_HOLD: if (kind == ACC_NONE) nxt = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) state <= ST_IDLE;
        else     state <= nxt;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            prog_rd_stb <= 1'b0;
            io_rd_stb   <= 1'b0;
            io_wr_stb   <= 1'b0;
            mem_rd_stb  <= 1'b0;
        end else begin
            prog_rd_stb <= 1'b0;
            io_rd_stb   <= 1'b0;
            io_wr_stb   <= 1'b0;
            mem_rd_stb  <= 1'b0;
            if (state == ST_IDLE) begin
                unique case (kind)
                    ACC_PROG:  prog_rd_stb <= 1'b1;
                    ACC_IORD:  io_rd_stb   <= 1'b1;
                    ACC_MEMRD: mem_rd_stb  <= 1'b1;
                    ACC_WR:    io_wr_stb   <= 1'b1;
                    ACC_NONE:  ;
                endcase
            end
        end
    end

    logic any_stb;
    assign any_stb = prog_rd_stb | io_rd_stb | io_wr_stb | mem_rd_stb;

    assert_strobe_exclusive_R8: assert property (@(posedge clk) disable iff (rst)
        $onehot0({prog_rd_stb, io_rd_stb, io_wr_stb, mem_rd_stb}));

    assert_no_write_in_prog_R8: assert property (@(posedge clk) disable iff (rst)
        (cfg_split_space && !pse_n_s) |=> !io_wr_stb);

    assert_single_pulse_R9: assert property (@(posedge clk) disable iff (rst)
        any_stb |=> !any_stb);

    assert_hold_no_restrobe_R9: assert property (@(posedge clk) disable iff (rst)
        (state == ST_HOLD) |=> !any_stb);

    assert_no_memrd_split_R6: assert property (@(posedge clk) disable iff (rst)
        cfg_split_space |=> !mem_rd_stb);

    assert_no_prog_combined_R7: assert property (@(posedge clk) disable iff (rst)
        !cfg_split_space |=> !(prog_rd_stb || io_rd_stb));
endmodule

// File: rtl/bus_strobe_adapter.sv
module bus_strobe_adapter #(
    parameter int AW = 8
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          pin_wr_dir,
    input  logic          pin_rd_en,
    input  logic          pin_ale,
    input  logic          pin_pse_n,
    input  logic [AW-1:0] bus_ad,
    input  logic          cfg_dir_mode,
    input  logic          cfg_ale_high,
    input  logic          cfg_split_space,
    output logic [AW-1:0] addr_q,
    output logic          prog_rd_stb,
    output logic          io_rd_stb,
    output logic          io_wr_stb,
    output logic          mem_rd_stb
);
    localparam int SW = AW + 4;

    logic [SW-1:0] raw_v, sync_v;
    logic [AW-1:0] bus_s;
    logic          wr_dir_s, rd_en_s, ale_s, pse_n_s;

    assign raw_v = {bus_ad, pin_wr_dir, pin_rd_en, pin_ale, pin_pse_n};
    assign {bus_s, wr_dir_s, rd_en_s, ale_s, pse_n_s} = sync_v;

    bsa_sync #(.W(SW)) u_sync (
        .clk (clk),
        .d   (raw_v),
        .q   (sync_v)
    );

    bsa_addr_capture #(.AW(AW)) u_addr (
        .clk          (clk),
        .rst          (rst),
        .ale_s        (ale_s),
        .cfg_ale_high (cfg_ale_high),
        .bus_s        (bus_s),
        .addr_q       (addr_q)
    );

    bsa_access_fsm u_fsm (
        .clk             (clk),
        .rst             (rst),
        .wr_dir_s        (wr_dir_s),
        .rd_en_s         (rd_en_s),
        .pse_n_s         (pse_n_s),
        .cfg_dir_mode    (cfg_dir_mode),
        .cfg_split_space (cfg_split_space),
        .prog_rd_stb     (prog_rd_stb),
        .io_rd_stb       (io_rd_stb),
        .io_wr_stb       (io_wr_stb),
        .mem_rd_stb      (mem_rd_stb)
    );
endmodule

// File: tb/sim_bus_strobe_adapter.sv
`timescale 1ns/1ps
module sim_bus_strobe_adapter;
    localparam int AW = 8;

    logic clk = 1'b0;
    always #2 clk = ~clk;

    logic          rst = 1'b1;
    logic          wr_dir = 1'b1, rd_en = 1'b1, ale = 1'b0, pse_n = 1'b1;
    logic [AW-1:0] bus = '0;
    logic          dir_mode = 1'b0, ale_high = 1'b1, split = 1'b1;
    logic [AW-1:0] addr_q;
    logic          prog_rd, io_rd, io_wr, mem_rd;

    bus_strobe_adapter #(.AW(AW)) u0 (
        .clk(clk), .rst(rst), .pin_wr_dir(wr_dir), .pin_rd_en(rd_en),
        .pin_ale(ale), .pin_pse_n(pse_n), .bus_ad(bus),
        .cfg_dir_mode(dir_mode), .cfg_ale_high(ale_high), .cfg_split_space(split),
        .addr_q(addr_q), .prog_rd_stb(prog_rd), .io_rd_stb(io_rd),
        .io_wr_stb(io_wr), .mem_rd_stb(mem_rd)
    );

    int vectors = 0;
    int errors  = 0;
    string phase = "R1";
    bit finished = 1'b0;

    // pin history: each entry {wr_dir, rd_en, ale, pse_n, bus}
    logic [AW+3:0] hist[$];
    logic [AW-1:0] e_addr = '0;
    logic [3:0]    e_stb = '0; // {prog, iord, iowr, memrd}
    bit            busy = 1'b0;

    // reference model, evaluated on every rising edge
    always @(posedge clk) begin
        logic [AW+3:0] old;
        logic w, r, a, p;
        logic [AW-1:0] b;
        bit rdc, wrc, active;
        logic [3:0] want;
        if (hist.size() >= 2) begin
            old = hist.pop_front();
            {w, r, a, p, b} = old;
            if (rst) begin
                e_addr = '0; e_stb = '0; busy = 0;
            end else begin
                if (ale_high ? a : !a) e_addr = b;
                rdc = dir_mode ? (r && w) : !r;
                wrc = dir_mode ? (r && !w) : !w;
                want = 4'b0000;
                if (split && !p)  want = 4'b1000;
                else if (rdc)     want = split ? 4'b0100 : 4'b0001;
                else if (wrc)     want = 4'b0010;
                active = (want != 0);
                e_stb  = busy ? 4'b0000 : want;
                busy   = active;
            end
        end else if (rst) begin
            e_addr = '0; e_stb = '0; busy = 0;
        end
        hist.push_back({wr_dir, rd_en, ale, pse_n, bus});
    end

    always @(negedge clk) begin
        if (!finished) begin
            vectors++;
            if (addr_q !== e_addr) begin
                errors++;
                $display("FAIL %s: addr_q actual %h expected %h", phase, addr_q, e_addr);
            end
            if ({prog_rd, io_rd, io_wr, mem_rd} !== e_stb) begin
                errors++;
                $display("FAIL %s: strobes {prog,iord,iowr,memrd} actual %b expected %b",
                         phase, {prog_rd, io_rd, io_wr, mem_rd}, e_stb);
            end
        end
    end

    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000 && !finished) begin
            finished = 1'b1;
            errors++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cyc);
            $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
            $finish;
        end
    end

    task automatic cycles(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic idle_pins();
        wr_dir = 1'b1;
        rd_en  = dir_mode ? 1'b0 : 1'b1;
        pse_n  = 1'b1;
        cycles(5);
    endtask

    task automatic set_cfg(bit dm, bit ah, bit sp);
        idle_pins();
        dir_mode = dm; ale_high = ah; split = sp;
        idle_pins();
    endtask

    task automatic random_run(int n);
        for (int i = 0; i < n; i++) begin
            wr_dir = 1'($urandom); rd_en = 1'($urandom);
            ale = 1'($urandom); pse_n = 1'($urandom);
            bus = AW'($urandom);
            cycles(1 + ($urandom % 3));
        end
    endtask

    initial begin
        phase = "R1";
        cycles(4);
        rst = 1'b0;
        cycles(3);

        phase = "R2";
        set_cfg(1'b0, 1'b1, 1'b1);
        wr_dir = 0; cycles(4); wr_dir = 1; cycles(4);
        rd_en = 0;  cycles(5); rd_en = 1;  cycles(4);
        wr_dir = 0; cycles(1); wr_dir = 1; cycles(5);

        phase = "R10";
        wr_dir = 0; rd_en = 0; cycles(4); wr_dir = 1; rd_en = 1; cycles(4);

        phase = "R6";
        pse_n = 0; cycles(4); pse_n = 1; cycles(4);
        rd_en = 0; cycles(3); rd_en = 1; cycles(4);

        phase = "R8";
        pse_n = 0; wr_dir = 0; cycles(5); pse_n = 1; wr_dir = 1; cycles(4);
        pse_n = 0; cycles(2); rd_en = 0; cycles(3); rd_en = 1; pse_n = 1; cycles(4);

        phase = "R9";
        pse_n = 0; cycles(4); wr_dir = 0; pse_n = 1; cycles(5); wr_dir = 1; cycles(4);
        rd_en = 0; cycles(12); rd_en = 1; cycles(4);

        phase = "R7";
        set_cfg(1'b0, 1'b1, 1'b0);
        pse_n = 0; cycles(5); pse_n = 1; cycles(4);
        rd_en = 0; pse_n = 0; cycles(4); rd_en = 1; pse_n = 1; cycles(4);
        pse_n = 0; wr_dir = 0; cycles(4); pse_n = 1; wr_dir = 1; cycles(4);

        phase = "R3";
        set_cfg(1'b1, 1'b1, 1'b1);
        wr_dir = 0; cycles(2); wr_dir = 1; cycles(2); wr_dir = 0; cycles(3); wr_dir = 1; cycles(3);
        rd_en = 1; cycles(4); rd_en = 0; cycles(4);
        wr_dir = 0; rd_en = 1; cycles(4); rd_en = 0; wr_dir = 1; cycles(4);

        phase = "R4";
        set_cfg(1'b0, 1'b1, 1'b1);
        ale = 1; bus = 8'h3C; cycles(2); bus = 8'hA5; cycles(2);
        ale = 0; cycles(1); bus = 8'h11; cycles(3); bus = 8'hFF; cycles(3);

        phase = "R5";
        ale = 1; cycles(3);
        set_cfg(1'b0, 1'b0, 1'b1);
        bus = 8'h5A; cycles(3);
        ale = 0; bus = 8'hC3; cycles(2); bus = 8'h7E; cycles(2);
        ale = 1; cycles(1); bus = 8'h00; cycles(4);

        phase = "R9";
        for (int c = 0; c < 8; c++) begin
            set_cfg(c[0], c[1], c[2]);
            random_run(150);
        end
        idle_pins();

        phase = "R1";
        rst = 1'b1; cycles(3); rst = 1'b0; cycles(3);

        finished = 1'b1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
        $finish;
    end
endmodule